// File: doc/BRIEF.md
# Binary float to extended-precision load converter

This block takes an IEEE single-precision or double-precision operand and turns it into the 80-bit x87 extended-precision form. This is the conversion done when a floating-point load pushes a value onto the register stack. A size select picks the source format. Every operand class is handled the x87 way:

- Normals are rebiased.
- Zeros and infinities keep their sign.
- Subnormals are normalized with a leading-one detector and a barrel shifter.
- Signalling NaNs are quieted.
- An unmasked invalid operation cancels the push.

The block also builds the status word that goes with the result. It carries through the condition codes of the incoming status word, it sets TOP for a push, and it adds the denormal, invalid, summary and busy flags. The two control-word mask bits, denormal and invalid, decide whether an exception is unmasked.

The classification, normalization and result assembly are combinational. One output register stage follows them. A valid strobe travels with the data, so a result is presented exactly one clock after its operand.

Top module: `fpx_ext_load`

## Requirements
- R1: For an operand that raises no exception, out_fsw has TOP (bits 13:11) equal to 7 and copies C0 (bit 8), C2 (bit 10) and C3 (bit 14) from in_fsw. Every other bit is 0.
- R2: A normal operand gives:
  - the sign copied to bit 79;
  - integer bit 63 set;
  - the source fraction left-justified into bits 62:0, a shift of 40 for single and 11 for double;
  - the exponent rebiased from 127 or 1023 to 16383, in bits 78:64.
- R3: A zero operand gives its sign in bit 79, with all of bits 78:0 zero.
- R4: A subnormal operand is normalized so that its highest set fraction bit becomes integer bit 63. The exponent is 16383 minus the source bias, minus (fraction width − 1 − position of that bit). The smallest single subnormal therefore gives an unbiased exponent of −149. DE (bit 1) is set.
- R5: A subnormal operand with dnrm_mask low also sets ES (bit 7) and B (bit 15). Result bits and TOP are the same as in the masked case.
- R6: An infinite operand gives its sign, exponent 0x7FFF and a mantissa with only bit 63 set. No flag is raised.
- R7: A quiet NaN (top fraction bit 1) gives its sign, exponent 0x7FFF, integer bit 1 and the fraction left-justified as in R2. No flag is raised.
- R8: A signalling NaN (top fraction bit 0, fraction non-zero) with inv_mask high gives the R7 result with bit 62 forced to 1. IE (bit 0) is set.
- R9: A signalling NaN with inv_mask low gives an all-zero 80-bit result. IE, ES and B are set, TOP is 0, and the condition codes are still copied.
- R10: After reset out_valid, out_val and out_fsw are 0. out_valid is high exactly in the cycle after a cycle with in_valid high.
- R11: With in_dbl low the operand is in_op[31:0] (sign 31, exponent 30:23, fraction 22:0), and in_op[63:32] has no effect. With in_dbl high the operand uses sign 63, exponent 62:52 and fraction 51:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_dbl | input | 1 | 1 selects double precision, 0 selects single |
| in_op | input | 64 | Source operand (single in the low 32 bits) |
| in_fsw | input | 16 | Incoming status word, source of the condition codes |
| dnrm_mask | input | 1 | Control-word denormal mask, 1 = masked |
| inv_mask | input | 1 | Control-word invalid-operation mask, 1 = masked |
| out_valid | output | 1 | Result present this cycle |
| out_val | output | 80 | Extended result: sign 79, exponent 78:64, integer bit 63, fraction 62:0 |
| out_fsw | output | 16 | Result status word |

## Verification
Carrying the condition codes through and cancelling the push for an unmasked signalling NaN both act on the same status word in the same cycle. The bench provokes this by driving in_fsw with every bit set while sending unmasked signalling NaNs in both sizes. It then requires TOP to read 0 while C0, C2 and C3 survive. A second overlap is the denormal flag with the summary and busy bits. The bench sends the same subnormal with the mask high and then low, and requires identical result bits with only ES and B differing. Operands are also sent back to back and between idle gaps. A behavioural model is compared against the design on every clock.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

   typedef enum logic [2:0] {
      FC_ZERO,
      FC_SUB,
      FC_NORM,
      FC_INF,
      FC_QNAN,
      FC_SNAN
   } fpx_class_e;

   localparam int FSW_W       = 16;
   localparam int FSW_IE      = 0;
   localparam int FSW_DE      = 1;
   localparam int FSW_ES      = 7;
   localparam int FSW_C0      = 8;
   localparam int FSW_C2      = 10;
   localparam int FSW_TOP_LSB = 11;
   localparam int FSW_TOP_W   = 3;
   localparam int FSW_C3      = 14;
   localparam int FSW_B       = 15;

endpackage

// File: rtl/fpx_unpack.sv
module fpx_unpack #(
   parameter int EXP_W      = 8,
   parameter int FRAC_W     = 23,
   parameter int EXT_EXP_W  = 15,
   parameter int EXT_FRAC_W = 63
) (
   input  logic [EXP_W+FRAC_W:0]     op,
   output logic                      sign,
   output fpx_pkg::fpx_class_e       cls,
   output logic [EXT_FRAC_W-1:0]     frac_lj,
   output logic [EXT_EXP_W-1:0]      exp_norm,
   output logic [EXT_EXP_W-1:0]      exp_subb
);
   import fpx_pkg::*;

   localparam int TOT_W    = EXP_W + FRAC_W + 1;
   localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
   localparam int EXT_BIAS = (1 << (EXT_EXP_W - 1)) - 1;
   localparam int JUST     = EXT_FRAC_W - FRAC_W;
   localparam int DELTA    = EXT_BIAS - BIAS;

   generate
      if (JUST < 1) begin : g_bad_frac
         $error("fpx_unpack: source fraction must be narrower than the extended fraction");
      end
      if (EXP_W >= EXT_EXP_W) begin : g_bad_exp
         $error("fpx_unpack: source exponent must be narrower than the extended exponent");
      end
   endgenerate

   logic [EXP_W-1:0]  e_fld;
   logic [FRAC_W-1:0] f_fld;
   logic              e_zero;
   logic              e_full;
   logic              f_zero;

   assign sign   = op[TOT_W-1];
   assign e_fld  = op[TOT_W-2:FRAC_W];
   assign f_fld  = op[FRAC_W-1:0];
   assign e_zero = (e_fld == '0);
   assign e_full = (e_fld == '1);
   assign f_zero = (f_fld == '0);

   assign frac_lj  = {f_fld, {JUST{1'b0}}};
   assign exp_norm = EXT_EXP_W'(e_fld) + EXT_EXP_W'(DELTA);
   assign exp_subb = EXT_EXP_W'(DELTA);

   always_comb begin
      if (e_zero)
         cls = f_zero ? FC_ZERO : FC_SUB;
      else if (e_full) begin
         if (f_zero)
            cls = FC_INF;
         else if (f_fld[FRAC_W-1])
            cls = FC_QNAN;
         else
            cls = FC_SNAN;
      end else
         cls = FC_NORM;
   end

endmodule

// File: rtl/fpx_lead_one.sv
module fpx_lead_one #(
   parameter int W     = 63,
   parameter int IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     vec,
   output logic [IDX_W-1:0] idx
);

   generate
      if (W < 2) begin : g_bad_w
         $error("fpx_lead_one: width must be at least 2");
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < W; i++) begin
         if (vec[i])
            idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/fpx_shl.sv
module fpx_shl #(
   parameter int W    = 64,
   parameter int SH_W = $clog2(W)
) (
   input  logic [W-1:0]    din,
   input  logic [SH_W-1:0] amt,
   output logic [W-1:0]    dout
);

   logic [W-1:0] stg [0:SH_W];

   assign stg[0] = din;

   generate
      for (genvar s = 0; s < SH_W; s++) begin : g_stage
         assign stg[s+1] = amt[s] ? (stg[s] << (1 << s)) : stg[s];
      end
   endgenerate

   assign dout = stg[SH_W];

endmodule

// File: rtl/fpx_ext_load.sv
module fpx_ext_load #(
   parameter int SGL_EXP_W  = 8,
   parameter int SGL_FRAC_W = 23,
   parameter int DBL_EXP_W  = 11,
   parameter int DBL_FRAC_W = 52,
   parameter int EXT_EXP_W  = 15,
   parameter int EXT_FRAC_W = 63,
   localparam int SGL_W     = SGL_EXP_W + SGL_FRAC_W + 1,
   localparam int DBL_W     = DBL_EXP_W + DBL_FRAC_W + 1,
   localparam int MANT_W    = EXT_FRAC_W + 1,
   localparam int OUT_W     = 1 + EXT_EXP_W + MANT_W,
   localparam int SW_W      = fpx_pkg::FSW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_dbl,
   input  logic [DBL_W-1:0]  in_op,
   input  logic [SW_W-1:0]   in_fsw,
   input  logic              dnrm_mask,
   input  logic              inv_mask,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_val,
   output logic [SW_W-1:0]   out_fsw
);
   import fpx_pkg::*;

   localparam int IDX_W = $clog2(EXT_FRAC_W);
   localparam int SH_W  = $clog2(MANT_W);

   generate
      if (SGL_W > DBL_W) begin : g_bad_sizes
         $error("fpx_ext_load: single format must not be wider than double");
      end
      if ((1 << SH_W) < MANT_W) begin : g_bad_shift
         $error("fpx_ext_load: shift amount too narrow");
      end
   endgenerate

   // per-format unpack
   logic                  s_sign, d_sign;
   fpx_class_e            s_cls, d_cls;
   logic [EXT_FRAC_W-1:0] s_frac, d_frac;
   logic [EXT_EXP_W-1:0]  s_expn, d_expn;
   logic [EXT_EXP_W-1:0]  s_subb, d_subb;

   fpx_unpack #(
      .EXP_W      (SGL_EXP_W),
      .FRAC_W     (SGL_FRAC_W),
      .EXT_EXP_W  (EXT_EXP_W),
      .EXT_FRAC_W (EXT_FRAC_W)
   ) u_unp_sgl (
      .op       (in_op[SGL_W-1:0]),
      .sign     (s_sign),
      .cls      (s_cls),
      .frac_lj  (s_frac),
      .exp_norm (s_expn),
      .exp_subb (s_subb)
   );

   fpx_unpack #(
      .EXP_W      (DBL_EXP_W),
      .FRAC_W     (DBL_FRAC_W),
      .EXT_EXP_W  (EXT_EXP_W),
      .EXT_FRAC_W (EXT_FRAC_W)
   ) u_unp_dbl (
      .op       (in_op),
      .sign     (d_sign),
      .cls      (d_cls),
      .frac_lj  (d_frac),
      .exp_norm (d_expn),
      .exp_subb (d_subb)
   );

   // size select
   logic                  op_sign;
   fpx_class_e            op_cls;
   logic [EXT_FRAC_W-1:0] op_frac;
   logic [EXT_EXP_W-1:0]  op_expn;
   logic [EXT_EXP_W-1:0]  op_subb;

   always_comb begin
      if (in_dbl) begin
         op_sign = d_sign;
         op_cls  = d_cls;
         op_frac = d_frac;
         op_expn = d_expn;
         op_subb = d_subb;
      end else begin
         op_sign = s_sign;
         op_cls  = s_cls;
         op_frac = s_frac;
         op_expn = s_expn;
         op_subb = s_subb;
      end
   end

   // shared normalization on the left-justified fraction
   logic [IDX_W-1:0]  lead_idx;
   logic [SH_W-1:0]   norm_amt;
   logic [MANT_W-1:0] sub_mant;
   logic [EXT_EXP_W-1:0] sub_exp;

   fpx_lead_one #(
      .W     (EXT_FRAC_W),
      .IDX_W (IDX_W)
   ) u_lod (
      .vec (op_frac),
      .idx (lead_idx)
   );

   assign norm_amt = SH_W'(MANT_W - 1) - SH_W'(lead_idx);

   fpx_shl #(
      .W    (MANT_W),
      .SH_W (SH_W)
   ) u_shl (
      .din  ({1'b0, op_frac}),
      .amt  (norm_amt),
      .dout (sub_mant)
   );

   assign sub_exp = op_subb - EXT_EXP_W'(EXT_FRAC_W - 1) + EXT_EXP_W'(lead_idx);

   // R4: after normalization the leading one sits in the integer bit
   always_comb begin
      if (rst_n && in_valid && (op_cls == FC_SUB))
         a_r4_norm_lead: assert (sub_mant[MANT_W-1])
            else $error("a_r4_norm_lead: normalized subnormal lost its leading one");
   end

   // result assembly
   logic                 r_sign;
   logic [EXT_EXP_W-1:0] r_exp;
   logic [MANT_W-1:0]    r_mant;
   logic [SW_W-1:0]      r_fsw;

   always_comb begin
      r_fsw = '0;
      r_fsw[FSW_TOP_LSB +: FSW_TOP_W] = '1;
      r_fsw[FSW_C0] = in_fsw[FSW_C0];
      r_fsw[FSW_C2] = in_fsw[FSW_C2];
      r_fsw[FSW_C3] = in_fsw[FSW_C3];
      r_sign = op_sign;
      r_exp  = '0;
      r_mant = '0;
      unique case (op_cls)
         FC_ZERO: begin
            r_exp  = '0;
            r_mant = '0;
         end
         FC_NORM: begin
            r_exp  = op_expn;
            r_mant = {1'b1, op_frac};
         end
         FC_SUB: begin
            r_exp  = sub_exp;
            r_mant = sub_mant;
            r_fsw[FSW_DE] = 1'b1;
            if (!dnrm_mask) begin
               r_fsw[FSW_ES] = 1'b1;
               r_fsw[FSW_B]  = 1'b1;
            end
         end
         FC_INF: begin
            r_exp  = '1;
            r_mant = {1'b1, {EXT_FRAC_W{1'b0}}};
         end
         FC_QNAN: begin
            r_exp  = '1;
            r_mant = {1'b1, op_frac};
         end
         FC_SNAN: begin
            r_exp  = '1;
            r_mant = {1'b1, 1'b1, op_frac[EXT_FRAC_W-2:0]};
            r_fsw[FSW_IE] = 1'b1;
            if (!inv_mask) begin
               r_fsw[FSW_TOP_LSB +: FSW_TOP_W] = '0;
               r_fsw[FSW_ES] = 1'b1;
               r_fsw[FSW_B]  = 1'b1;
               r_sign = 1'b0;
               r_exp  = '0;
               r_mant = '0;
            end
         end
         default: begin
            r_exp  = '0;
            r_mant = '0;
         end
      endcase
   end

   // output register stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_val   <= '0;
         out_fsw   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_val <= {r_sign, r_exp, r_mant};
            out_fsw <= r_fsw;
         end
      end
   end

   // R1: a result without an invalid flag is a push with TOP at 7
   a_r1_top_on_push: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_fsw[FSW_IE] |-> out_fsw[FSW_TOP_LSB +: FSW_TOP_W] == '1)
      else $error("a_r1_top_on_push");

   // R9: a cancelled push carries an all-zero value and the invalid flags
   a_r9_cancel_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (out_fsw[FSW_TOP_LSB +: FSW_TOP_W] == '0) |->
         (out_val == '0) && out_fsw[FSW_IE] && out_fsw[FSW_ES] && out_fsw[FSW_B])
      else $error("a_r9_cancel_zero");

   // R5: the summary and busy bits always travel together
   a_r5_es_b_pair: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_fsw[FSW_ES] == out_fsw[FSW_B])
      else $error("a_r5_es_b_pair");

   // R8: denormal and invalid flags never come from one operand
   a_r8_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_fsw[FSW_DE] && out_fsw[FSW_IE]))
      else $error("a_r8_flag_excl");

   // R2: any non-zero exponent comes with the integer bit set
   a_r2_int_bit: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (out_val[OUT_W-2 -: EXT_EXP_W] != '0) |-> out_val[MANT_W-1])
      else $error("a_r2_int_bit");

endmodule

// File: tb/fpx_ext_load_tb.sv
`timescale 1ns/1ps
module fpx_ext_load_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        in_dbl;
   logic [63:0] in_op;
   logic [15:0] in_fsw;
   logic        dnrm_mask;
   logic        inv_mask;
   logic        out_valid;
   logic [79:0] out_val;
   logic [15:0] out_fsw;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic        vld;
      logic [79:0] v;
      logic [15:0] f;
      string       vt;
      string       ft;
   } exp_t;

   exp_t pend[$];

   always #4 clk = ~clk;

   fpx_ext_load u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_dbl    (in_dbl),
      .in_op     (in_op),
      .in_fsw    (in_fsw),
      .dnrm_mask (dnrm_mask),
      .inv_mask  (inv_mask),
      .out_valid (out_valid),
      .out_val   (out_val),
      .out_fsw   (out_fsw)
   );

   task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural model of the conversion
   function automatic void model(input bit dbl, input logic [63:0] op, input logic [15:0] fi,
                                 input bit dm, input bit im,
                                 output logic [79:0] v, output logic [15:0] fs,
                                 output string vt, output string ft);
      int ebits, fbits, bias, emax, ex, p;
      logic [63:0] f, mant;
      logic sg;
      logic [15:0] e;
      ebits = dbl ? 11 : 8;
      fbits = dbl ? 52 : 23;
      bias  = (1 << (ebits - 1)) - 1;
      emax  = (1 << ebits) - 1;
      if (dbl) begin
         sg = op[63]; e = 16'(op[62:52]); f = {12'b0, op[51:0]};
      end else begin
         sg = op[31]; e = 16'(op[30:23]); f = {41'b0, op[22:0]};
      end
      fs = 16'h3800 | (fi & 16'h4500);
      ft = "R1";
      ex = 0; mant = 0;
      if (e == 0 && f == 0) begin
         vt = "R3";
      end else if (e == 0) begin
         p = 0;
         for (int i = 0; i < 64; i++) if (f[i]) p = i;
         ex = 16383 - bias - (fbits - 1 - p);
         mant = f << (63 - p);
         fs = fs | 16'h0002;
         vt = "R4"; ft = "R4";
         if (!dm) begin
            fs = fs | 16'h8080;
            vt = "R5"; ft = "R5";
         end
      end else if (e == 16'(emax) && f == 0) begin
         ex = 32767; mant = 64'h8000_0000_0000_0000;
         vt = "R6";
      end else if (e == 16'(emax)) begin
         ex = 32767;
         mant = 64'h8000_0000_0000_0000 | (f << (63 - fbits));
         if (f[fbits-1]) begin
            vt = "R7"; ft = "R7";
         end else begin
            mant = mant | 64'h4000_0000_0000_0000;
            fs = fs | 16'h0001;
            vt = "R8"; ft = "R8";
         end
      end else begin
         ex = int'(e) - bias + 16383;
         mant = 64'h8000_0000_0000_0000 | (f << (63 - fbits));
         vt = "R2";
      end
      v = {sg, ex[14:0], mant};
      if (vt == "R8" && !im) begin
         fs = (fs & ~16'h3800) | 16'h8080;
         v = '0;
         vt = "R9"; ft = "R9";
      end
   endfunction

   // one clock: check last cycle's expectation, then drive this cycle
   task automatic step(input bit vld, input bit dbl, input logic [63:0] op,
                       input logic [15:0] fi, input bit dm, input bit im, input string tag);
      exp_t cur;
      exp_t nxt;
      @(negedge clk);
      if (pend.size() > 0) begin
         cur = pend.pop_front();
         chk("R10 valid", 80'(out_valid), 80'(cur.vld));
         if (cur.vld && out_valid) begin
            chk(cur.vt, out_val, cur.v);
            chk(cur.ft, 80'(out_fsw), 80'(cur.f));
         end
      end
      in_valid  = vld;
      in_dbl    = dbl;
      in_op     = op;
      in_fsw    = fi;
      dnrm_mask = dm;
      inv_mask  = im;
      nxt.vld = vld;
      model(dbl, op, fi, dm, im, nxt.v, nxt.f, nxt.vt, nxt.ft);
      if (tag != "") begin
         nxt.vt = tag;
         nxt.ft = tag;
      end
      pend.push_back(nxt);
   endtask

   task automatic go(input bit dbl, input logic [63:0] op, input logic [15:0] fi,
                     input bit dm, input bit im);
      step(1'b1, dbl, op, fi, dm, im, "");
   endtask

   task automatic idle();
      step(1'b0, 1'b0, {$urandom, $urandom}, 16'($urandom), 1'b1, 1'b1, "");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_dbl = 1'b0; in_op = '0;
      in_fsw = '0; dnrm_mask = 1'b1; inv_mask = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk("R10 reset valid", 80'(out_valid), 80'(0));
      chk("R10 reset val", out_val, 80'(0));
      chk("R10 reset fsw", 80'(out_fsw), 80'(0));
      rst_n = 1'b1;

      // single precision, garbage in the upper half
      go(0, 64'hDEADBEEF_3F800000, 16'hFFFF, 1, 1);
      go(0, 64'h12345678_C0200000, 16'h0000, 1, 1);
      go(0, 64'hFFFFFFFF_7F7FFFFF, 16'h4500, 1, 1);
      go(0, 64'h0_00800000,        16'hBAFF, 1, 1);
      go(0, 64'hAAAAAAAA_00000000, 16'hFFFF, 1, 1);
      go(0, 64'h0_80000000,        16'h0100, 1, 1);
      go(0, 64'h0_00000001,        16'h0400, 1, 1);
      go(0, 64'h0_00000001,        16'h0400, 0, 1);
      go(0, 64'h0_807FFFFF,        16'hFFFF, 1, 1);
      go(0, 64'h0_00400000,        16'h4000, 0, 1);
      go(0, 64'h0_7F800000,        16'hFFFF, 1, 1);
      go(0, 64'h0_FF800000,        16'h0000, 1, 1);
      go(0, 64'h0_7FC00001,        16'hFFFF, 1, 0);
      go(0, 64'h0_FFC00000,        16'h0000, 1, 0);
      go(0, 64'h0_7F800001,        16'hFFFF, 1, 1);
      go(0, 64'h0_7F800001,        16'hFFFF, 1, 0);
      idle();
      go(0, 64'h0_FFA00000,        16'h4500, 1, 0);
      idle();
      idle();
      // double precision
      go(1, 64'h3FF0000000000000, 16'hFFFF, 1, 1);
      go(1, 64'hC004000000000000, 16'h0000, 1, 1);
      go(1, 64'h7FEFFFFFFFFFFFFF, 16'h4500, 1, 1);
      go(1, 64'h0000000000000000, 16'hBAFF, 1, 1);
      go(1, 64'h8000000000000000, 16'hFFFF, 1, 1);
      go(1, 64'h0000000000000001, 16'hFFFF, 1, 1);
      go(1, 64'h0000000000000001, 16'hFFFF, 0, 1);
      go(1, 64'h800FFFFFFFFFFFFF, 16'h0400, 0, 0);
      go(1, 64'h7FF0000000000000, 16'hFFFF, 0, 0);
      go(1, 64'hFFF0000000000000, 16'h0000, 1, 1);
      go(1, 64'h7FF8000000000001, 16'hFFFF, 0, 0);
      go(1, 64'h7FF0000000000001, 16'h4500, 1, 1);
      go(1, 64'h7FF0000000000001, 16'hFFFF, 1, 0);
      go(1, 64'hFFF4000000000000, 16'h0000, 0, 0);
      idle();

      // R11: upper half ignored for single size
      step(1, 0, 64'h00000000_3F800000, 16'h0000, 1, 1, "R11");
      step(1, 0, 64'hFFFFFFFF_3F800000, 16'h0000, 1, 1, "R11");
      step(1, 0, 64'h7FF00000_00000003, 16'h0000, 0, 0, "R11");

      // random mix of classes, sizes and gaps
      for (int n = 0; n < 400; n++) begin
         logic [63:0] r;
         bit dbl;
         int k;
         r = {$urandom, $urandom};
         dbl = 1'($urandom);
         k = int'($urandom % 4);
         if (dbl) begin
            if (k == 0) r[62:52] = '0;
            if (k == 1) r[62:52] = '1;
            if ($urandom % 4 == 0) r[51:0] = '0;
         end else begin
            if (k == 0) r[30:23] = '0;
            if (k == 1) r[30:23] = '1;
            if ($urandom % 4 == 0) r[22:0] = '0;
         end
         if ($urandom % 5 == 0) idle();
         go(dbl, r, 16'($urandom), 1'($urandom), 1'($urandom));
      end
      idle();
      idle();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule